// File: doc/BRIEF.md
# Biphase Mark Line Encoder

This block turns a stream of single data bits into one self-clocking serial line. Each bit occupies one cell made of two half-cells of equal length. The line always flips at the start of a cell, and it flips again halfway through only when the bit is a 1. A receiver can therefore recover both timing and data from the transitions, and the absolute level carries no information.

A free-running divider counts system clocks and produces a one-cycle strobe every `HALF_CELL_CYCLES` clocks. The phase register and the line register change only on that strobe. Near the end of the first half of each cell, the block pulses `in_ready` for one cycle. The bit offered with `in_valid` in that cycle is taken and applied at the mid-cell edge. If no bit is offered, a parameterised fill value is encoded, so the line keeps its clock transitions. `line_out` is driven directly by a flip-flop.

Top module: `bmk_line_encoder`

## Requirements
- R1: While reset is asserted and at the first clock after its release, `line_out` is 1, the encoder is in the first half of a cell, and `in_ready` is 0.
- R2: The half-cell strobe fires exactly once every `HALF_CELL_CYCLES` clocks, counted from reset release, so both halves of every cell last the same number of clocks.
- R3: `line_out` and the phase change only on a clock edge at which the half-cell strobe is active. Between strobes the line holds its level.
- R4: At every edge that ends a second half-cell, `line_out` inverts, which marks the cell boundary.
- R5: At every edge that ends a first half-cell, with a valid bit offered, `line_out` becomes its previous value XOR that bit. A 0 appears as 00 or 11 across the two halves, and a 1 appears as 01 or 10.
- R6: `in_ready` is high only in the single clock before the edge that ends a first half-cell. A bit is accepted when `in_valid` is high in that clock.
- R7: If `in_valid` is low when `in_ready` is high, `in_bit` is ignored and the `IDLE_BIT` value (default 0) is encoded in that cell instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A data bit is offered |
| in_bit | input | 1 | Data bit to encode |
| in_ready | output | 1 | One-cycle request; bit taken at the next edge |
| line_out | output | 1 | Registered biphase mark line |

## Verification
Runs of all zeros show that only boundary flips occur, so the line toggles once per cell. Runs of all ones show a mid-cell flip in every cell. An alternating pattern shows that the decoder reads the transition within each cell, not the line level. Idle cells are run with `in_bit` set to the opposite of the fill value, which tells acceptance apart from the fill path. A pseudo-random run mixes all of these cases. A scoreboard decodes each cell from the line level sampled at the start and end of each half. It compares the XOR of the two halves against the queued bit, and it checks that each boundary flips, that each half is stable and the same length, and that the request appears only in the first half.

// File: rtl/bmk_pkg.sv
`timescale 1ns/1ps
package bmk_pkg;
   // Which half of the current bit cell the encoder is in
   typedef enum logic {
      HALF_FIRST  = 1'b0,
      HALF_SECOND = 1'b1
   } half_e;
endpackage

// File: rtl/bmk_half_timer.sv
`timescale 1ns/1ps
module bmk_half_timer #(
   parameter int HALF_CELL_CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   output logic half_stb
);
   localparam int CW = (HALF_CELL_CYCLES > 1) ? $clog2(HALF_CELL_CYCLES) : 1;
   localparam logic [CW-1:0] LAST = CW'(HALF_CELL_CYCLES - 1);
   localparam bit IS_POW2 = ((HALF_CELL_CYCLES & (HALF_CELL_CYCLES - 1)) == 0);

   logic [CW-1:0] cnt_q;

   assign half_stb = (cnt_q == LAST);

   generate
      if (IS_POW2) begin : g_wrap
         // power-of-two length: natural wrap, no compare on the reload path
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt_q <= '0;
            else        cnt_q <= cnt_q + 1'b1;
         end
      end else begin : g_clear
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        cnt_q <= '0;
            else if (half_stb) cnt_q <= '0;
            else               cnt_q <= cnt_q + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/bmk_cell_fsm.sv
`timescale 1ns/1ps
module bmk_cell_fsm #(
   parameter bit IDLE_BIT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              half_stb,
   input  logic              in_valid,
   input  logic              in_bit,
   output logic              in_ready,
   output logic              line_out,
   output bmk_pkg::half_e    phase_o
);
   import bmk_pkg::*;

   half_e phase_q, phase_d;
   logic  line_q, line_d;
   logic  cell_bit;

   assign in_ready = half_stb && (phase_q == HALF_FIRST);
   assign cell_bit = in_valid ? in_bit : IDLE_BIT;

   always_comb begin
      phase_d = phase_q;
      line_d  = line_q;
      if (half_stb) begin
         case (phase_q)
            HALF_FIRST: begin
               line_d  = line_q ^ cell_bit;
               phase_d = HALF_SECOND;
            end
            default: begin
               line_d  = ~line_q;
               phase_d = HALF_FIRST;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= HALF_FIRST;
         line_q  <= 1'b1;
      end else begin
         phase_q <= phase_d;
         line_q  <= line_d;
      end
   end

   assign line_out = line_q;
   assign phase_o  = phase_q;
endmodule

// File: rtl/bmk_line_encoder.sv
`timescale 1ns/1ps
module bmk_line_encoder #(
   parameter int HALF_CELL_CYCLES = 8,
   parameter bit IDLE_BIT         = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_valid,
   input  logic in_bit,
   output logic in_ready,
   output logic line_out
);
   generate
      if (HALF_CELL_CYCLES < 2) begin : g_bad_half
         $error("bmk_line_encoder: HALF_CELL_CYCLES must be at least 2");
      end
   endgenerate

   logic           half_stb;
   bmk_pkg::half_e phase_w;

   bmk_half_timer #(
      .HALF_CELL_CYCLES(HALF_CELL_CYCLES)
   ) timer_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .half_stb (half_stb)
   );

   bmk_cell_fsm #(
      .IDLE_BIT(IDLE_BIT)
   ) fsm_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .half_stb (half_stb),
      .in_valid (in_valid),
      .in_bit   (in_bit),
      .in_ready (in_ready),
      .line_out (line_out),
      .phase_o  (phase_w)
   );
endmodule

// File: rtl/bmk_line_encoder_chk.sv
`timescale 1ns/1ps
module bmk_line_encoder_chk #(
   parameter int HALF_CELL_CYCLES = 8,
   parameter bit IDLE_BIT         = 1'b0
) (
   input logic           clk,
   input logic           rst_n,
   input logic           in_valid,
   input logic           in_bit,
   input logic           in_ready,
   input logic           line_out,
   input logic           half_stb,
   input bmk_pkg::half_e phase
);
   import bmk_pkg::*;

   int gap_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        gap_q <= 0;
      else if (half_stb) gap_q <= 0;
      else               gap_q <= gap_q + 1;
   end

   // R1
   reset_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (line_out && phase == HALF_FIRST && !in_ready));

   // R2
   half_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
      half_stb |-> (gap_q == HALF_CELL_CYCLES - 1));

   // R2
   gap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gap_q < HALF_CELL_CYCLES);

   // R3
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !half_stb |=> ($stable(line_out) && $stable(phase)));

   // R4
   boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (half_stb && phase == HALF_SECOND) |=> (line_out != $past(line_out) && phase == HALF_FIRST));

   // R5
   midcell_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (half_stb && phase == HALF_FIRST && in_valid) |=> (line_out == ($past(line_out) ^ $past(in_bit))));

   // R6
   ready_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> (half_stb && phase == HALF_FIRST));

   // R7
   idle_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready && !in_valid) |=> (line_out == ($past(line_out) ^ IDLE_BIT)));
endmodule

bind bmk_line_encoder bmk_line_encoder_chk #(
   .HALF_CELL_CYCLES(HALF_CELL_CYCLES),
   .IDLE_BIT(IDLE_BIT)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .in_bit   (in_bit),
   .in_ready (in_ready),
   .line_out (line_out),
   .half_stb (half_stb),
   .phase    (phase_w)
);

// File: tb/bmk_line_encoder_tb_top.sv
`timescale 1ns/1ps
module bmk_line_encoder_tb_top;
   localparam int HALF        = 5;
   localparam bit IDLE        = 1'b0;
   localparam int TOTAL_CELLS = 41;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic in_bit = 1'b0;
   logic in_ready;
   logic line_out;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;
   logic [1:0] exp_q[$];   // {came_from_idle, bit}

   always #10 clk = ~clk;

   bmk_line_encoder #(.HALF_CELL_CYCLES(HALF), .IDLE_BIT(IDLE)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit),
      .in_ready(in_ready), .line_out(line_out)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // driver side of the scoreboard: push the expected bit once the request is seen
   task automatic wait_accept(input logic [1:0] item);
      #1;
      while (!in_ready) begin
         @(negedge clk);
         #1;
      end
      exp_q.push_back(item);
      @(negedge clk);
   endtask

   task automatic send_bit(input logic b);
      in_valid = 1'b1;
      in_bit   = b;
      wait_accept({1'b0, b});
      in_valid = 1'b0;
   endtask

   task automatic idle_cell();
      in_valid = 1'b0;
      in_bit   = ~IDLE;            // must be ignored (R7)
      wait_accept({1'b1, IDLE});
   endtask

   task automatic drive();
      logic [7:0] lf = 8'hA5;
      for (int i = 0; i < 6; i++) send_bit(1'b0);
      for (int i = 0; i < 6; i++) send_bit(1'b1);
      for (int i = 0; i < 8; i++) send_bit(i[0]);
      for (int i = 0; i < 3; i++) idle_cell();
      for (int i = 0; i < 16; i++) begin
         send_bit(lf[0]);
         lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      end
      for (int i = 0; i < 2; i++) idle_cell();
   endtask

   // monitor: samples the line at the start and end of each half-cell
   task automatic run_monitor();
      logic a_start, a_end, b_start, b_end, prev_b;
      logic [1:0] item;
      prev_b = 1'b0;
      for (int c = 0; c < TOTAL_CELLS; c++) begin
         a_start = line_out;
         if (c == 0) chk(a_start == 1'b1, "R1 first level", a_start, 1);
         else        chk(a_start != prev_b, "R4 boundary flip", a_start, !prev_b);
         repeat (HALF - 1) @(posedge clk);
         @(negedge clk);
         a_end = line_out;
         chk(a_end == a_start, "R3 first half stable", a_end, a_start);
         chk(in_ready == 1'b1, "R6 request in first half", in_ready, 1);
         @(posedge clk);
         @(negedge clk);
         b_start = line_out;
         repeat (HALF - 1) @(posedge clk);
         @(negedge clk);
         b_end = line_out;
         chk(b_end == b_start, "R2 second half stable", b_end, b_start);
         chk(in_ready == 1'b0, "R6 no request in second half", in_ready, 0);
         if (exp_q.size() == 0) begin
            chk(1'b0, "R5 scoreboard empty", 0, 1);
         end else begin
            item = exp_q.pop_front();
            if (item[1]) chk((a_end ^ b_end) == item[0], "R7 idle fill", a_end ^ b_end, item[0]);
            else         chk((a_end ^ b_end) == item[0], "R5 data bit", a_end ^ b_end, item[0]);
         end
         prev_b = b_end;
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(line_out == 1'b1, "R1 reset line", line_out, 1);
      chk(in_ready == 1'b0, "R1 reset ready", in_ready, 0);
      @(negedge clk);
      rst_n = 1'b1;
      fork
         run_monitor();
         drive();
      join
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule